// File: doc/BRIEF.md
# Fixed-Point Spiking Neuron Integrator

This block advances a two-variable spiking neuron model in hardware. A membrane variable V and a recovery variable U are held as 18-bit two's complement words with 16 fractional bits. Each update applies one forward-Euler step. The time step is a plain arithmetic right shift, so no divider is needed. V follows a quadratic law driven by fixed bias terms. U relaxes towards a scaled copy of V.

When V rises above a fixed spike level, the Euler result is discarded. V snaps to a fixed reset value and U takes a fixed increment.

The block is clocked by the audio frame clock and steps its state once in every nine frames. A downstream serializer can take the upper 16 bits of either output as a DAC sample. All model constants are build-time parameters.

Top module: `neuron_integrator`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the state loads V = 0x34CCD (-0.7) and U = 0x3CCCD (-0.2). Both outputs show these values from that edge on.
- R2: The state steps only on update cycles. The first update is at the first rising edge after `rst` is low. Each later update comes 9 edges after the one before. On all other edges `v_out` and `u_out` hold their value.
- R3: On a non-spiking update, V becomes V + asr2(dV). Here dV = V² + V + asr2(V) + asr2(0x16666) − asr2(U) + asr2(0x02666). All sums wrap modulo 2^18.
- R4: On a non-spiking update, U becomes U + asr2(dU). Here dU = a·(b·V − U), with a = 0x0051E and b = 0x03333. All sums wrap modulo 2^18.
- R5: Every product (V², b·V and a·(b·V − U)) is formed at full 36-bit signed precision. The result keeps bit 35 as its sign, followed by product bits 32 down to 16.
- R6: On an update where V is greater than the spike level 0x04CCC, the next V is 0x38000. The next U is U + 0x0051E.
- R7: The spike comparison treats V as signed. A V with bit 17 set never takes the spike path.
- R8: asr2(x) is an arithmetic shift right by two bits that copies bit 17 into the two vacated top bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Frame clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to the initial state |
| v_out | output | 18 | Membrane variable V, signed, 16 fractional bits |
| u_out | output | 18 | Recovery variable U, signed, 16 fractional bits |

## Verification
After reset is released, the first new state appears one rising edge later. Every ninth edge after that carries the next one. Each result is registered directly into the output state, with no further stages.

The bench keeps its own phase counter from the release of reset. It samples both outputs at the falling edge after every rising edge. On the update phase it expects the bit-exact value from its own integer model of the equations; on every other phase it expects the previous value. A reset asserted in the middle of a frame group checks that the phase restarts from the release edge, and not from the old count.

// File: rtl/neuron_pkg.sv
package neuron_pkg;

    localparam int unsigned WORD_W = 18;
    localparam int unsigned FRAC_W = 16;

    typedef logic signed [WORD_W-1:0] fx_t;

    typedef struct packed {
        fx_t v;
        fx_t u;
    } nstate_t;

    // model constants, Q2.16
    localparam fx_t V_INIT   = 18'sh34CCD;
    localparam fx_t U_INIT   = 18'sh3CCCD;
    localparam fx_t K_A      = 18'sh0051E;
    localparam fx_t K_B      = 18'sh03333;
    localparam fx_t K_DRIVE  = 18'sh16666;
    localparam fx_t K_BIAS   = 18'sh02666;
    localparam fx_t K_SPIKE  = 18'sh04CCC;
    localparam fx_t K_VRESET = 18'sh38000;
    localparam fx_t K_UKICK  = 18'sh0051E;

    // divide by four, keeping the sign
    function automatic fx_t asr2(input fx_t x);
        return x >>> 2;
    endfunction

endpackage

// File: rtl/neuron_prescaler.sv
module neuron_prescaler #(
    parameter int unsigned COUNT = 9
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (COUNT > 1) ? $clog2(COUNT) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == CW'(COUNT - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign tick = (cnt == '0);

endmodule

// File: rtl/neuron_frac_mul.sv
module neuron_frac_mul #(
    parameter int unsigned W = 18,
    parameter int unsigned F = 16
) (
    input  logic signed [W-1:0] op_a,
    input  logic signed [W-1:0] op_b,
    output logic signed [W-1:0] prod
);
    localparam int unsigned PW = 2 * W;

    logic signed [PW-1:0] full;

    assign full = op_a * op_b;

    // sign bit, then the W-1 bits just above the dropped fraction
    assign prod = {full[PW-1], full[F+W-2:F]};

endmodule

// File: rtl/neuron_euler.sv
module neuron_euler
    import neuron_pkg::*;
#(
    parameter fx_t P_A      = K_A,
    parameter fx_t P_B      = K_B,
    parameter fx_t P_DRIVE  = K_DRIVE,
    parameter fx_t P_BIAS   = K_BIAS,
    parameter fx_t P_SPIKE  = K_SPIKE,
    parameter fx_t P_VRESET = K_VRESET,
    parameter fx_t P_UKICK  = K_UKICK
) (
    input  nstate_t cur,
    output nstate_t eul,
    output nstate_t nxt
);
    fx_t v_sq;
    fx_t v_b;
    fx_t gap;
    fx_t u_rate;
    fx_t v_rate;
    logic fire;

    neuron_frac_mul #(.W(WORD_W), .F(FRAC_W)) mul_sq (
        .op_a (cur.v),
        .op_b (cur.v),
        .prod (v_sq)
    );

    neuron_frac_mul #(.W(WORD_W), .F(FRAC_W)) mul_bv (
        .op_a (cur.v),
        .op_b (P_B),
        .prod (v_b)
    );

    assign gap = v_b - cur.u;

    neuron_frac_mul #(.W(WORD_W), .F(FRAC_W)) mul_au (
        .op_a (P_A),
        .op_b (gap),
        .prod (u_rate)
    );

    always_comb begin
        v_rate = v_sq + (cur.v + asr2(cur.v)) + asr2(P_DRIVE)
               - asr2(cur.u) + asr2(P_BIAS);
        eul.v  = cur.v + asr2(v_rate);
        eul.u  = cur.u + asr2(u_rate);
        fire   = (cur.v > P_SPIKE);
        if (fire) begin
            nxt.v = P_VRESET;
            nxt.u = cur.u + P_UKICK;
        end else begin
            nxt = eul;
        end
    end

endmodule

// File: rtl/neuron_integrator.sv
module neuron_integrator
    import neuron_pkg::*;
#(
    parameter int unsigned PRESCALE = 9,
    parameter fx_t P_VINIT  = V_INIT,
    parameter fx_t P_UINIT  = U_INIT,
    parameter fx_t P_SPIKE  = K_SPIKE,
    parameter fx_t P_VRESET = K_VRESET,
    parameter fx_t P_UKICK  = K_UKICK
) (
    input  logic              clk,
    input  logic              rst,
    output logic [WORD_W-1:0] v_out,
    output logic [WORD_W-1:0] u_out
);
    logic    tick;
    fx_t     v_q;
    fx_t     u_q;
    fx_t     v_eul;
    fx_t     u_eul;
    nstate_t cur;
    nstate_t eul;
    nstate_t nxt;

    neuron_prescaler #(.COUNT(PRESCALE)) pre_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    assign cur.v = v_q;
    assign cur.u = u_q;

    neuron_euler #(
        .P_SPIKE  (P_SPIKE),
        .P_VRESET (P_VRESET),
        .P_UKICK  (P_UKICK)
    ) step_i (
        .cur (cur),
        .eul (eul),
        .nxt (nxt)
    );

    assign v_eul = eul.v;
    assign u_eul = eul.u;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= P_VINIT;
            u_q <= P_UINIT;
        end else if (tick) begin
            v_q <= nxt.v;
            u_q <= nxt.u;
        end
    end

    assign v_out = v_q;
    assign u_out = u_q;

endmodule

// File: rtl/neuron_integrator_chk.sv
module neuron_integrator_chk
    import neuron_pkg::*;
#(
    parameter int unsigned PRESCALE = 9,
    parameter fx_t P_VINIT  = V_INIT,
    parameter fx_t P_UINIT  = U_INIT,
    parameter fx_t P_SPIKE  = K_SPIKE,
    parameter fx_t P_VRESET = K_VRESET,
    parameter fx_t P_UKICK  = K_UKICK
) (
    input logic clk,
    input logic rst,
    input logic upd,
    input fx_t  v,
    input fx_t  u,
    input fx_t  v_eul,
    input fx_t  u_eul
);
    logic [15:0] gap;
    logic        seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (upd) begin
            gap  <= '0;
            seen <= 1'b1;
        end else begin
            gap  <= gap + 16'd1;
        end
    end

    AST_RESET_LOAD: assert property (@(posedge clk)
        rst |=> (v == P_VINIT) && (u == P_UINIT)); // R1

    AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(v) && $stable(u)); // R2

    AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (upd && seen) |-> (gap == 16'(PRESCALE - 1))); // R2

    AST_EULER_V: assert property (@(posedge clk) disable iff (rst)
        (upd && !(v > P_SPIKE)) |=> (v == $past(v_eul))); // R3

    AST_EULER_U: assert property (@(posedge clk) disable iff (rst)
        (upd && !(v > P_SPIKE)) |=> (u == $past(u_eul))); // R4

    AST_SPIKE_RESET: assert property (@(posedge clk) disable iff (rst)
        (upd && (v > P_SPIKE)) |=> (v == P_VRESET) && (u == $past(u) + P_UKICK)); // R6

    AST_NEG_NO_SPIKE: assert property (@(posedge clk) disable iff (rst)
        (upd && v[WORD_W-1]) |=> (v == $past(v_eul))); // R7

endmodule

bind neuron_integrator neuron_integrator_chk #(
    .PRESCALE (PRESCALE),
    .P_VINIT  (P_VINIT),
    .P_UINIT  (P_UINIT),
    .P_SPIKE  (P_SPIKE),
    .P_VRESET (P_VRESET),
    .P_UKICK  (P_UKICK)
) chk_i (
    .clk   (clk),
    .rst   (rst),
    .upd   (tick),
    .v     (v_q),
    .u     (u_q),
    .v_eul (v_eul),
    .u_eul (u_eul)
);

// File: tb/neuron_integrator_test.sv
`timescale 1ns/1ps
module neuron_integrator_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [17:0] v_out;
    logic [17:0] u_out;

    int n_checks = 0;
    int n_errors = 0;
    int n_spikes = 0;
    int n_neg    = 0;

    logic [17:0] mv;
    logic [17:0] mu;

    always #2.5 clk = ~clk;

    neuron_integrator uut (
        .clk   (clk),
        .rst   (rst),
        .v_out (v_out),
        .u_out (u_out)
    );

    // reference arithmetic written from the requirements
    function automatic logic [17:0] r_mul(input logic [17:0] x, input logic [17:0] y);
        longint      p;
        logic [63:0] pb;
        p  = longint'($signed(x)) * longint'($signed(y));
        pb = p;
        return {pb[35], pb[32:16]};
    endfunction

    function automatic logic [17:0] r_sh(input logic [17:0] x);
        return {x[17], x[17], x[17:2]};
    endfunction

    function automatic logic r_fire(input logic [17:0] x);
        return $signed(x) > $signed(18'h04CCC);
    endfunction

    task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic [17:0] dv, du, vb;
        if (r_fire(mv)) begin
            mv = 18'h38000;
            mu = mu + 18'h0051E;
        end else begin
            dv = r_mul(mv, mv) + (mv + r_sh(mv)) + r_sh(18'h16666)
               - r_sh(mu) + r_sh(18'h02666);
            vb = r_mul(mv, 18'h03333);
            du = r_mul(18'h0051E, vb - mu);
            mv = mv + r_sh(dv);
            mu = mu + r_sh(du);
        end
    endtask

    // R1: reset values appear and are held while rst stays high
    task automatic t_reset(input int cycles);
        rst = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R1 V reset", v_out, 18'h34CCD);
            chk("R1 U reset", u_out, 18'h3CCCD);
        end
        mv = 18'h34CCD;
        mu = 18'h3CCCD;
    endtask

    // R2..R8: release reset at a falling edge, then follow every edge
    task automatic t_run(input int cycles);
        logic        fired;
        logic        neg;
        logic [17:0] pv, pu;
        rst = 1'b0;
        for (int k = 0; k < cycles; k++) begin
            pv = mv;
            pu = mu;
            fired = 1'b0;
            neg = 1'b0;
            if ((k % 9) == 0) begin
                fired = r_fire(mv);
                neg = mv[17];
                model_step();
            end
            @(posedge clk);
            @(negedge clk);
            if ((k % 9) != 0) begin
                chk("R2 V hold", v_out, pv);
                chk("R2 U hold", u_out, pu);
            end else if (fired) begin
                n_spikes++;
                chk("R6 V spike reset", v_out, mv);
                chk("R6 U spike kick", u_out, mu);
            end else begin
                if (neg) n_neg++;
                chk(neg ? "R7 R3 R5 R8 V step" : "R3 R5 R8 V step", v_out, mv);
                chk(neg ? "R7 R4 R5 R8 U step" : "R4 R5 R8 U step", u_out, mu);
            end
        end
    endtask

    task automatic t_count(input string tag, input int got);
        n_checks++;
        if (got == 0) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=nonzero", tag, got);
        end
    endtask

    initial begin
        #(150000 * 5);
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset(4);
        t_run(9 * 1500);
        t_count("R6 spikes seen", n_spikes);
        t_count("R7 negative updates seen", n_neg);
        // mid-group reset: phase must restart from release
        t_run(5);
        t_reset(2);
        t_run(9 * 300 + 4);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule